// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general register file of a 32-bit RISC core in which the physical register behind a register number depends on the processor mode held in the current status register. Eight low registers and the program counter are one set for every mode. The fast-interrupt mode has its own copies of registers 8 to 14. The interrupt, supervisor, abort and undefined modes each own only a stack pointer (r13) and a link register (r14). Each of these five exception modes also keeps one saved status register.

The core reads two registers combinationally and writes one register per clock. The program counter has its own read and write path. The current status register can be written as a whole. The saved status register of the current mode has its own read and write port. An exception entry input takes one cycle to switch the core into a target mode. In that cycle it saves the old status word, loads the return address into the target mode's link register and masks interrupts.

Top module: `bank_regfile`

## Requirements
- R1: While reset is held and in the first cycle after it, the status word reads 0x000000D3: mode bits [4:0] = 10011 (supervisor), interrupt mask bit 7 = 1, fast-interrupt mask bit 6 = 1, state bit 5 = 0. The program counter reads RESET_PC (default 0). With CLEAR_ON_RESET = 1, every general register and every saved status register reads 0.
- R2: Registers 0 to 7 are one physical set. A value written in any mode reads back unchanged in every other mode.
- R3: In fast-interrupt mode (mode 10001), registers 8 to 14 are private copies. In every other mode, registers 8 to 12 are the copies used in user mode (10000).
- R4: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have private r13 and r14. System mode (11111) uses exactly the user-mode registers.
- R5: Reading index 15 on either read port returns the program counter. pc_we loads pc_wdata. A general write to index 15 loads the program counter only when pc_we is low in the same cycle.
- R6: spsr_rd shows the saved status register of the current mode, and spsr_we writes it. In user or system mode spsr_rd reads 0 and spsr_we changes no saved status register.
- R7: An exception entry to one of the five exception modes (exc_en high) acts on the next clock edge. It stores the old status word in the target mode's saved status register and loads exc_lr into the target mode's r14. The new status word keeps bits 31:8 and bit 6, sets bit 7, clears bit 5 and takes exc_mode in bits 4:0. Bit 6 is also set when the target is fast-interrupt mode.
- R8: An exception entry whose exc_mode is user, system or not in the encoding list changes no state.
- R9: In the cycle of an exception entry, a status-word write and a saved-status write are ignored. The entry's r14 load wins over a general write to the same physical register. A general write to any other register still happens and uses the mode in force before the entry.
- R10: A mode field outside the seven listed codes raises mode_illegal and selects registers as user mode does. In that mode spsr_rd reads 0.
- R11: The read ports are combinational, so a read in the cycle of a write returns the old value. The written value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write register number |
| wr_data | input | XLEN | General write data |
| pc_out | output | XLEN | Program counter |
| pc_we | input | 1 | Program counter write enable |
| pc_wdata | input | XLEN | Program counter write data |
| cpsr_out | output | 32 | Current status word |
| cpsr_we | input | 1 | Status word write enable |
| cpsr_wdata | input | 32 | Status word write data |
| spsr_rd | output | 32 | Saved status of the current mode |
| spsr_we | input | 1 | Saved status write enable |
| spsr_wdata | input | 32 | Saved status write data |
| exc_en | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of the exception entry |
| exc_lr | input | XLEN | Return address for the target r14 |
| mode_illegal | output | 1 | Current mode field is not a listed code |

## Verification
The case that matters most is an exception entry that lands in the same cycle as ordinary writes: a status-word write, a saved-status write and a general write to r14. Directed steps build this clash on purpose. One step enters from user mode, so the general r14 write and the entry's r14 load go to different physical registers. Another re-enters the mode that is already current, so both target the same register. The random phase fires entries about one cycle in sixteen, alongside independently drawn writes. A bench model applies the priority rules in order, and each cycle's reads, status words and program counter are compared with that model.

// File: rtl/brf_pkg.sv
package brf_pkg;

  localparam int unsigned PSR_W = 32;
  localparam int unsigned MODE_W = 5;

  localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

  localparam int unsigned BIT_IMASK = 7;
  localparam int unsigned BIT_FMASK = 6;
  localparam int unsigned BIT_STATE = 5;

  // physical layout: shared low regs, user high regs, fast-irq high regs, pair banks
  localparam int unsigned N_LOW      = 8;
  localparam int unsigned N_HIGH     = 7;
  localparam int unsigned N_PAIRBANK = 4;
  localparam int unsigned BASE_UHI   = N_LOW;
  localparam int unsigned BASE_FHI   = BASE_UHI + N_HIGH;
  localparam int unsigned BASE_PAIR  = BASE_FHI + N_HIGH;
  localparam int unsigned NPHYS      = BASE_PAIR + 2 * N_PAIRBANK;
  localparam int unsigned PHYS_W     = $clog2(NPHYS);
  localparam int unsigned NUM_SAVED  = 1 + N_PAIRBANK;

  localparam logic [PSR_W-1:0] PSR_RESET = {24'h0, 1'b1, 1'b1, 1'b0, MD_SVC};

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  function automatic bank_e mode_bank(input logic [MODE_W-1:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;
    endcase
  endfunction

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return (m == MD_USR) || (m == MD_SYS) || (mode_bank(m) != BK_USR);
  endfunction

  function automatic logic [PHYS_W-1:0] phys_sel(input bank_e b, input logic [3:0] idx);
    int unsigned n;
    n = int'(idx);
    if (n < N_LOW)
      return PHYS_W'(n);
    if (b == BK_FIQ)
      return PHYS_W'(BASE_FHI + n - N_LOW);
    if (b != BK_USR && n >= 13)
      return PHYS_W'(BASE_PAIR + 2 * (int'(b) - 2) + n - 13);
    return PHYS_W'(n);
  endfunction

  function automatic logic [PSR_W-1:0] entry_psr(input logic [PSR_W-1:0] old_psr,
                                                 input logic [MODE_W-1:0] tgt);
    logic [PSR_W-1:0] r;
    r = old_psr;
    r[MODE_W-1:0] = tgt;
    r[BIT_IMASK]  = 1'b1;
    r[BIT_STATE]  = 1'b0;
    if (tgt == MD_FIQ)
      r[BIT_FMASK] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/brf_mode_dec.sv
module brf_mode_dec
  import brf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank,
  output logic              legal
);
  assign bank  = mode_bank(mode);
  assign legal = mode_legal(mode);
endmodule

// File: rtl/brf_gpr_store.sv
module brf_gpr_store #(
  parameter int unsigned XLEN           = 32,
  parameter int unsigned NENT           = 30,
  parameter int unsigned SEL_W          = 5,
  parameter bit          CLEAR_ON_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ra_sel,
  output logic [XLEN-1:0]  ra_data,
  input  logic [SEL_W-1:0] rb_sel,
  output logic [XLEN-1:0]  rb_data,
  input  logic             w0_en,
  input  logic [SEL_W-1:0] w0_sel,
  input  logic [XLEN-1:0]  w0_data,
  input  logic             w1_en,
  input  logic [SEL_W-1:0] w1_sel,
  input  logic [XLEN-1:0]  w1_data
);
  logic [NENT-1:0][XLEN-1:0] ent;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic            hit0;
    logic            hit1;
    logic [XLEN-1:0] q;
    assign hit0 = w0_en && (w0_sel == SEL_W'(g));
    assign hit1 = w1_en && (w1_sel == SEL_W'(g));
    if (CLEAR_ON_RESET) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (hit1) q <= w1_data;
        else if (hit0) q <= w0_data;
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (hit1)      q <= w1_data;
        else if (hit0) q <= w0_data;
      end
    end
    assign ent[g] = q;
  end

  assign ra_data = ent[ra_sel];
  assign rb_data = ent[rb_sel];
endmodule

// File: rtl/brf_psr_unit.sv
module brf_psr_unit
  import brf_pkg::*;
#(
  parameter bit CLEAR_ON_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             cur_bank,
  input  logic              entry_fire,
  input  bank_e             entry_bank,
  input  logic [MODE_W-1:0] entry_mode,
  input  logic              cpsr_we,
  input  logic [PSR_W-1:0]  cpsr_wdata,
  input  logic              spsr_we,
  input  logic [PSR_W-1:0]  spsr_wdata,
  output logic [PSR_W-1:0]  cpsr,
  output logic [PSR_W-1:0]  spsr_rd
);
  logic [NUM_SAVED-1:0][PSR_W-1:0] saved;
  logic [2:0]                      rd_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cpsr <= PSR_RESET;
    else if (entry_fire) cpsr <= entry_psr(cpsr, entry_mode);
    else if (cpsr_we)    cpsr <= cpsr_wdata;
  end

  for (genvar k = 0; k < NUM_SAVED; k++) begin : g_saved
    logic             take_entry;
    logic             take_sw;
    logic [PSR_W-1:0] q;
    assign take_entry = entry_fire && (int'(entry_bank) == k + 1);
    assign take_sw    = spsr_we && !entry_fire && (int'(cur_bank) == k + 1);
    if (CLEAR_ON_RESET) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= '0;
        else if (take_entry) q <= cpsr;
        else if (take_sw)    q <= spsr_wdata;
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (take_entry)   q <= cpsr;
        else if (take_sw) q <= spsr_wdata;
      end
    end
    assign saved[k] = q;
  end

  assign rd_slot = 3'(cur_bank) - 3'd1;
  assign spsr_rd = (cur_bank == BK_USR) ? '0 : saved[rd_slot];
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import brf_pkg::*;
#(
  parameter int unsigned XLEN           = 32,
  parameter bit          CLEAR_ON_RESET = 1'b1,
  parameter logic [XLEN-1:0] RESET_PC   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_idx,
  output logic [XLEN-1:0]   rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [XLEN-1:0]   rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [XLEN-1:0]   wr_data,
  output logic [XLEN-1:0]   pc_out,
  input  logic              pc_we,
  input  logic [XLEN-1:0]   pc_wdata,
  output logic [PSR_W-1:0]  cpsr_out,
  input  logic              cpsr_we,
  input  logic [PSR_W-1:0]  cpsr_wdata,
  output logic [PSR_W-1:0]  spsr_rd,
  input  logic              spsr_we,
  input  logic [PSR_W-1:0]  spsr_wdata,
  input  logic              exc_en,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic [XLEN-1:0]   exc_lr,
  output logic              mode_illegal
);
  localparam logic [3:0] IDX_PC = 4'd15;
  localparam logic [3:0] IDX_LR = 4'd14;

  // named internal events used by the checker
  bank_e             cur_bank;
  bank_e             ent_bank;
  logic              cur_legal;
  logic              ent_legal;
  logic              entry_fire;
  logic              gen_wr_gpr;
  logic              gen_wr_pc;
  logic [PHYS_W-1:0] sel_a;
  logic [PHYS_W-1:0] sel_b;
  logic [PHYS_W-1:0] sel_w;
  logic [PHYS_W-1:0] sel_lr;
  logic [XLEN-1:0]   gpr_a;
  logic [XLEN-1:0]   gpr_b;
  logic [XLEN-1:0]   pc_q;

  brf_mode_dec u_dec_cur (.mode(cpsr_out[MODE_W-1:0]), .bank(cur_bank), .legal(cur_legal));
  brf_mode_dec u_dec_ent (.mode(exc_mode), .bank(ent_bank), .legal(ent_legal));

  assign entry_fire = exc_en && ent_legal && (ent_bank != BK_USR);
  assign gen_wr_gpr = wr_en && (wr_idx != IDX_PC);
  assign gen_wr_pc  = wr_en && (wr_idx == IDX_PC) && !pc_we;

  assign sel_a  = phys_sel(cur_bank, rd_a_idx);
  assign sel_b  = phys_sel(cur_bank, rd_b_idx);
  assign sel_w  = phys_sel(cur_bank, wr_idx);
  assign sel_lr = phys_sel(ent_bank, IDX_LR);

  brf_gpr_store #(
    .XLEN(XLEN), .NENT(NPHYS), .SEL_W(PHYS_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_sel(sel_a), .ra_data(gpr_a),
    .rb_sel(sel_b), .rb_data(gpr_b),
    .w0_en(gen_wr_gpr), .w0_sel(sel_w), .w0_data(wr_data),
    .w1_en(entry_fire), .w1_sel(sel_lr), .w1_data(exc_lr)
  );

  brf_psr_unit #(.CLEAR_ON_RESET(CLEAR_ON_RESET)) u_psr (
    .clk(clk), .rst_n(rst_n),
    .cur_bank(cur_bank),
    .entry_fire(entry_fire), .entry_bank(ent_bank), .entry_mode(exc_mode),
    .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata),
    .cpsr(cpsr_out), .spsr_rd(spsr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pc_q <= RESET_PC;
    else if (pc_we)     pc_q <= pc_wdata;
    else if (gen_wr_pc) pc_q <= wr_data;
  end

  assign pc_out       = pc_q;
  assign rd_a_data    = (rd_a_idx == IDX_PC) ? pc_q : gpr_a;
  assign rd_b_data    = (rd_b_idx == IDX_PC) ? pc_q : gpr_b;
  assign mode_illegal = !cur_legal;
endmodule

// File: rtl/brf_checker.sv
module brf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cpsr_out,
  input logic [31:0] spsr_rd,
  input logic        pc_we,
  input logic [31:0] pc_wdata,
  input logic [31:0] pc_out,
  input logic        exc_en,
  input logic [4:0]  exc_mode,
  input logic        cpsr_we,
  input logic        mode_illegal,
  input logic        entry_fire
);
  logic [4:0] md;
  logic       md_known;
  logic       md_plain;
  logic       tgt_plain;
  assign md        = cpsr_out[4:0];
  assign md_known  = (md == 5'b10000) || (md == 5'b10001) || (md == 5'b10010) ||
                     (md == 5'b10011) || (md == 5'b10111) || (md == 5'b11011) ||
                     (md == 5'b11111);
  assign md_plain  = (md == 5'b10000) || (md == 5'b11111);
  assign tgt_plain = (exc_mode == 5'b10000) || (exc_mode == 5'b11111);

  p_reset_psr_r1: assert property (@(posedge clk) !rst_n |=> (cpsr_out == 32'h0000_00D3));

  p_pc_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (pc_out == $past(pc_wdata)));

  p_no_saved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    md_plain |-> (spsr_rd == 32'h0));

  p_entry_psr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fire |=> (cpsr_out[4:0] == $past(exc_mode)) && cpsr_out[7] && !cpsr_out[5] &&
                   (cpsr_out[31:28] == $past(cpsr_out[31:28])));

  p_entry_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fire |=> (spsr_rd == $past(cpsr_out)));

  p_entry_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && tgt_plain && !cpsr_we) |=> (cpsr_out == $past(cpsr_out)));

  p_entry_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_fire && cpsr_we) |=> (cpsr_out[4:0] == $past(exc_mode)));

  p_illegal_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_illegal == !md_known);

  p_illegal_saved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_illegal |-> (spsr_rd == 32'h0));
endmodule

bind bank_regfile brf_checker u_chk (.*);

// File: tb/sim_bank_regfile.sv
`timescale 1ns/1ps
module sim_bank_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, pc_out, cpsr_out, spsr_rd;
  logic        wr_en = 0, pc_we = 0, cpsr_we = 0, spsr_we = 0, exc_en = 0;
  logic [31:0] wr_data = '0, pc_wdata = '0, cpsr_wdata = '0, spsr_wdata = '0, exc_lr = '0;
  logic [4:0]  exc_mode = '0;
  logic        mode_illegal;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic [31:0] ureg [0:14];
  logic [31:0] freg [8:14];
  logic [31:0] bsp  [0:3];
  logic [31:0] blr  [0:3];
  logic [31:0] sav  [0:4];
  logic [31:0] m_pc, m_cpsr;

  always #5 clk = ~clk;

  bank_regfile u0 (.*);

  function automatic int cls(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic bit known(input logic [4:0] m);
    return (cls(m) != 0) || (m == 5'b10000) || (m == 5'b11111);
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] i, input logic [4:0] m);
    int c = cls(m);
    if (i == 4'd15) return m_pc;
    if (i < 8) return ureg[i];
    if (c == 1) return freg[i];
    if (c >= 2 && i == 4'd13) return bsp[c-2];
    if (c >= 2 && i == 4'd14) return blr[c-2];
    return ureg[i];
  endfunction

  task automatic m_write(input logic [3:0] i, input logic [4:0] m, input logic [31:0] d);
    int c = cls(m);
    if (i < 8) ureg[i] = d;
    else if (c == 1) freg[i] = d;
    else if (c >= 2 && i == 4'd13) bsp[c-2] = d;
    else if (c >= 2 && i == 4'd14) blr[c-2] = d;
    else ureg[i] = d;
  endtask

  function automatic logic [31:0] m_saved();
    int c = cls(m_cpsr[4:0]);
    return (c == 0) ? 32'h0 : sav[c-1];
  endfunction

  task automatic m_update();
    logic [31:0] oc = m_cpsr;
    int tc = cls(exc_mode);
    bit ent = exc_en && (tc != 0);
    if (wr_en) begin
      if (wr_idx == 4'd15) begin if (!pc_we) m_pc = wr_data; end
      else m_write(wr_idx, oc[4:0], wr_data);
    end
    if (pc_we) m_pc = pc_wdata;
    if (spsr_we && !ent && cls(oc[4:0]) != 0) sav[cls(oc[4:0])-1] = spsr_wdata;
    if (ent) begin
      m_write(4'd14, exc_mode, exc_lr);
      sav[tc-1] = oc;
      m_cpsr = {oc[31:8], 1'b1, oc[6] | (tc == 1), 1'b0, exc_mode};
    end else if (cpsr_we) m_cpsr = cpsr_wdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    m_update();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; pc_we = 0; cpsr_we = 0; spsr_we = 0; exc_en = 0;
  endtask

  task automatic set_mode(input logic [31:0] v);
    cpsr_we = 1; cpsr_wdata = v; step();
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; step();
  endtask

  task automatic rdchk(input string tag, input logic [3:0] i, input logic [31:0] e);
    rd_a_idx = i; rd_b_idx = i; #1;
    chk(tag, rd_a_data, e);
    chk(tag, rd_b_data, e);
  endtask

  task automatic enter(input logic [4:0] m, input logic [31:0] lr);
    exc_en = 1; exc_mode = m; exc_lr = lr; step();
  endtask

  initial begin
    for (int i = 0; i < 15; i++) ureg[i] = '0;
    for (int i = 8; i < 15; i++) freg[i] = '0;
    for (int i = 0; i < 4; i++) begin bsp[i] = '0; blr[i] = '0; end
    for (int i = 0; i < 5; i++) sav[i] = '0;
    m_pc = '0; m_cpsr = 32'h0000_00D3;
    void'($urandom(32'd20250601));
    repeat (3) @(negedge clk);
    #1 chk("R1 psr in reset", cpsr_out, 32'hD3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 psr", cpsr_out, 32'hD3);
    chk("R1 pc", pc_out, 32'h0);
    chk("R1 saved", spsr_rd, 32'h0);
    rdchk("R1 gpr", 4'd5, 32'h0);

    // banking across modes
    set_mode(32'h10);
    wr(4'd3, 32'hA3); wr(4'd9, 32'hB9); wr(4'd13, 32'hC13); wr(4'd14, 32'hD14);
    set_mode(32'h11);
    rdchk("R2 low shared fiq", 4'd3, 32'hA3);
    rdchk("R3 fiq r9 private", 4'd9, 32'h0);
    wr(4'd9, 32'hE9);
    set_mode(32'h12);
    rdchk("R3 irq sees user r9", 4'd9, 32'hB9);
    rdchk("R4 irq r13 private", 4'd13, 32'h0);
    rdchk("R2 low shared irq", 4'd3, 32'hA3);
    wr(4'd13, 32'hF13);
    set_mode(32'h1F);
    rdchk("R4 system r13", 4'd13, 32'hC13);
    rdchk("R4 system r14", 4'd14, 32'hD14);
    chk("R6 system saved zero", spsr_rd, 32'h0);
    spsr_we = 1; spsr_wdata = 32'h55; step();
    chk("R6 system saved write ignored", spsr_rd, 32'h0);

    // saved status per mode
    set_mode(32'h13);
    chk("R6 svc saved untouched", spsr_rd, 32'h0);
    spsr_we = 1; spsr_wdata = 32'h1234_5613; step();
    chk("R6 svc saved write", spsr_rd, 32'h1234_5613);
    set_mode(32'h17);
    chk("R6 abort saved separate", spsr_rd, 32'h0);
    set_mode(32'h13);
    chk("R6 svc saved kept", spsr_rd, 32'h1234_5613);

    // program counter path
    pc_we = 1; pc_wdata = 32'h100; step();
    chk("R5 pc load", pc_out, 32'h100);
    rdchk("R5 r15 read", 4'd15, 32'h100);
    wr(4'd15, 32'h200);
    chk("R5 general write r15", pc_out, 32'h200);
    pc_we = 1; pc_wdata = 32'h300; wr(4'd15, 32'h400);
    chk("R5 pc path wins", pc_out, 32'h300);

    // exception entry
    set_mode(32'hF000_0010);
    enter(5'b10010, 32'h88);
    chk("R7 irq entry psr", cpsr_out, 32'hF000_0092);
    chk("R7 irq entry saved", spsr_rd, 32'hF000_0010);
    rdchk("R7 irq entry lr", 4'd14, 32'h88);
    rdchk("R7 irq sp kept", 4'd13, 32'hF13);
    enter(5'b10001, 32'h99);
    chk("R7 fiq entry psr", cpsr_out, 32'hF000_00D1);
    chk("R7 fiq entry saved", spsr_rd, 32'hF000_0092);
    rdchk("R7 fiq entry lr", 4'd14, 32'h99);
    rdchk("R3 fiq r9 kept", 4'd9, 32'hE9);

    enter(5'b10000, 32'h1);
    chk("R8 user target ignored", cpsr_out, 32'hF000_00D1);
    enter(5'b11111, 32'h2);
    chk("R8 system target ignored", cpsr_out, 32'hF000_00D1);
    enter(5'b10101, 32'h3);
    chk("R8 unknown target ignored", cpsr_out, 32'hF000_00D1);
    rdchk("R8 lr untouched", 4'd14, 32'h99);

    // entry colliding with other writes
    set_mode(32'h10);
    exc_en = 1; exc_mode = 5'b10010; exc_lr = 32'h77;
    cpsr_we = 1; cpsr_wdata = 32'h13;
    spsr_we = 1; spsr_wdata = 32'h99;
    wr(4'd14, 32'h66);
    chk("R9 entry beats psr write", cpsr_out, 32'h92);
    chk("R9 entry beats saved write", spsr_rd, 32'h10);
    rdchk("R9 entry lr", 4'd14, 32'h77);
    exc_en = 1; exc_mode = 5'b10010; exc_lr = 32'h44;
    wr(4'd14, 32'h55);
    rdchk("R9 entry lr beats same reg write", 4'd14, 32'h44);
    chk("R9 reentry saved", spsr_rd, 32'h92);
    set_mode(32'h10);
    rdchk("R9 old-mode write landed", 4'd14, 32'h66);

    // illegal mode
    set_mode(32'h15);
    chk("R10 flag set", {31'h0, mode_illegal}, 32'h1);
    rdchk("R10 user r13 selected", 4'd13, 32'hC13);
    chk("R10 saved zero", spsr_rd, 32'h0);
    set_mode(32'h10);
    chk("R10 flag clear", {31'h0, mode_illegal}, 32'h0);

    // write then read timing
    wr_en = 1; wr_idx = 4'd6; wr_data = 32'hABCD;
    rd_a_idx = 4'd6; rd_b_idx = 4'd6; #1;
    chk("R11 read sees old value", rd_a_data, 32'h0);
    step();
    rdchk("R11 read sees new value", 4'd6, 32'hABCD);

    // random phase
    for (int it = 0; it < 4000; it++) begin
      logic [4:0] mlist [8];
      mlist = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111, 5'b10101};
      wr_en = ($urandom % 2) == 0;
      wr_idx = 4'($urandom);
      wr_data = $urandom;
      pc_we = ($urandom % 8) == 0;
      pc_wdata = $urandom;
      cpsr_we = ($urandom % 8) == 0;
      cpsr_wdata = {$urandom} & 32'hFFFF_FFE0 | {27'h0, mlist[$urandom % 8]};
      spsr_we = ($urandom % 8) == 0;
      spsr_wdata = $urandom;
      exc_en = ($urandom % 16) == 0;
      exc_mode = mlist[$urandom % 8];
      exc_lr = $urandom;
      rd_a_idx = 4'($urandom);
      rd_b_idx = 4'($urandom);
      #1;
      chk("R11 rand port a", rd_a_data, m_read(rd_a_idx, m_cpsr[4:0]));
      chk("R11 rand port b", rd_b_data, m_read(rd_b_idx, m_cpsr[4:0]));
      chk("R5 rand pc", pc_out, m_pc);
      chk("R7 rand psr", cpsr_out, m_cpsr);
      chk("R6 rand saved", spsr_rd, m_saved());
      chk("R10 rand flag", {31'h0, mode_illegal}, {31'h0, !known(m_cpsr[4:0])});
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule